// File: doc/BRIEF.md
# Four-Lane Alignment Deskew Buffer

The block takes four code-synchronized 10-bit character streams whose lanes arrive with different delays and removes that skew. The far end sends an alignment character on all four lanes in the same column; a per-lane flag marks where that character sits in each received stream. Each lane is written every cycle into its own small circular buffer. Control logic measures how far apart the four alignment flags land and sets each buffer's read pointer behind its write pointer by that amount. The alignment characters of one column then leave all four lanes in the same output cycle.

Alignment characters come at irregular intervals, so the block simply waits for them. A column is accepted only if its four flags fall within a tolerance of five characters. A column that is too wide, or a flag on one lane with no partners, drops alignment until a good column is seen again. Losing sync on any single lane drops alignment for the whole group. Output characters are forced to zero while the group is not aligned.

Top module: `lane_deskew`

## Requirements
- R1: While rst_ni is low, aligned_o is 0 and every lane_data_o and lane_mark_o bit is 0.
- R2: While aligned_o is 0, all lane_data_o and lane_mark_o bits are 0, whatever the inputs carry.
- R3: lane_mark_i[l]=1 marks an alignment character on lane l. A column is complete when every lane has flagged once and the last flag is sampled at most SKEW_MAX (5) cycles after the first. From the edge that samples the last flag, aligned_o is 1, lane_mark_o is 4'b1111, and lane l outputs after edge t the word {mark, data} sampled at edge t−d_l, where d_l is the number of cycles from lane l's flag to the last flag.
- R4: Any number of idle cycles (no flag on any lane) may separate columns; the alignment state and delays hold across them.
- R5: If a column opens and is not complete by the edge that samples the cycle SKEW_MAX after its first flag, aligned_o is 0 after that edge. This covers a lone flag on one lane and a spread of more than 5 cycles.
- R6: A later complete column with different spacing replaces the lane delays from its completing edge; aligned_o stays 1 and that column's flags leave together.
- R7: lane_sync_i[l]=1 means lane l is in sync. At any edge where some lane_sync_i bit is 0, a partially collected column is discarded, flags are ignored, and aligned_o is 0 after that edge.
- R8: A second flag on a lane whose flag is already collected in the open column is ignored; the lane keeps its first arrival.
- R9: A column that repeats the current spacing leaves aligned_o at 1 and emits lane_mark_o = 4'b1111 on its completing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_data_i | input | 4x10 | Received character per lane |
| lane_sync_i | input | 4 | Per-lane code-sync status, 1 = in sync |
| lane_mark_i | input | 4 | Per-lane alignment-character flag |
| lane_data_o | output | 4x10 | Deskewed character per lane |
| lane_mark_o | output | 4 | Deskewed alignment flag per lane |
| aligned_o | output | 1 | Group aligned; output valid |

## Verification
The hardest case to reach from the ports is a column that is still open when something interrupts it. Examples are a sync drop between the first and last flags, a repeated flag on one lane inside the window, and a window that ends exactly at the fifth cycle. The stimulus builds each column from explicit per-lane flag offsets. This places flags, sync drops and idle gaps at exact cycles relative to the window start. A behavioural model tracks arrival times in absolute cycles and keeps a history of the input words. Every output word is compared against that model in every cycle.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam int LANES  = 4;
  localparam int CODE_W = 10;
  localparam int WORD_W = CODE_W + 1;  // {mark, code}
endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
  parameter int DEPTH  = 8,   // power of two
  parameter int WORD_W = 11,
  parameter int PW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [PW-1:0]     rd_dly_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [DEPTH-1:0][WORD_W-1:0] mem_q;
  logic [PW-1:0]                wp_q;
  logic [PW-1:0]                rp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wp_q  <= '0;
    end else begin
      mem_q[wp_q] <= wr_word_i;
      wp_q        <= wp_q + 1'b1;
    end
  end

  // read pointer trails write pointer by the lane delay; zero delay bypasses
  assign rp        = wp_q - rd_dly_i;
  assign rd_word_o = (rd_dly_i == '0) ? wr_word_i : mem_q[rp];
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl #(
  parameter int LANES    = 4,
  parameter int SKEW_MAX = 5,
  parameter int PW       = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0]          sync_i,
  input  logic [LANES-1:0]          mark_i,
  output logic [LANES-1:0][PW-1:0]  dly_o,
  output logic                      aligned_nxt_o,
  output logic                      aligned_o
);
  localparam int CNT_W = $clog2(SKEW_MAX + 1);

  logic                         act_q, act_n;
  logic [CNT_W-1:0]             cnt_q, cnt_n;
  logic [LANES-1:0]             seen_q, seen_n, hit;
  logic [LANES-1:0][CNT_W-1:0]  arr_q, arr_n;
  logic [LANES-1:0][PW-1:0]     dly_q, dly_n;
  logic                         aln_q, aln_n;

  always_comb begin
    act_n  = act_q;
    cnt_n  = cnt_q;
    seen_n = seen_q;
    arr_n  = arr_q;
    dly_n  = dly_q;
    aln_n  = aln_q;
    hit    = mark_i & ~seen_q;
    if (!(&sync_i)) begin
      act_n  = 1'b0;
      cnt_n  = '0;
      seen_n = '0;
      aln_n  = 1'b0;
    end else if (act_q || (|mark_i)) begin
      for (int l = 0; l < LANES; l++)
        if (hit[l]) arr_n[l] = cnt_q;
      seen_n = seen_q | hit;
      if (&seen_n) begin
        for (int l = 0; l < LANES; l++)
          dly_n[l] = PW'(cnt_q - arr_n[l]);
        aln_n  = 1'b1;
        act_n  = 1'b0;
        cnt_n  = '0;
        seen_n = '0;
      end else if (cnt_q == CNT_W'(SKEW_MAX)) begin
        aln_n  = 1'b0;
        act_n  = 1'b0;
        cnt_n  = '0;
        seen_n = '0;
      end else begin
        act_n  = 1'b1;
        cnt_n  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      seen_q <= '0;
      arr_q  <= '0;
      dly_q  <= '0;
      aln_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
      arr_q  <= arr_n;
      dly_q  <= dly_n;
      aln_q  <= aln_n;
    end
  end

  assign dly_o         = dly_n;
  assign aligned_nxt_o = aln_n;
  assign aligned_o     = aln_q;

  // R7
  sync_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&sync_i) |=> !aligned_o);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R3
    dly_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dly_q[l] <= PW'(SKEW_MAX));
  end
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import deskew_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SKEW_MAX = 5   // must be below DEPTH
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LANES-1:0][CODE_W-1:0]  lane_data_i,
  input  logic [LANES-1:0]              lane_sync_i,
  input  logic [LANES-1:0]              lane_mark_i,
  output logic [LANES-1:0][CODE_W-1:0]  lane_data_o,
  output logic [LANES-1:0]              lane_mark_o,
  output logic                          aligned_o
);
  localparam int PW = $clog2(DEPTH);

  logic [LANES-1:0][PW-1:0]     dly_nxt;
  logic                         aligned_nxt;
  logic [LANES-1:0][WORD_W-1:0] rd_word;
  logic [LANES-1:0][WORD_W-1:0] out_q;

  deskew_ctrl #(
    .LANES(LANES), .SKEW_MAX(SKEW_MAX), .PW(PW)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sync_i        (lane_sync_i),
    .mark_i        (lane_mark_i),
    .dly_o         (dly_nxt),
    .aligned_nxt_o (aligned_nxt),
    .aligned_o     (aligned_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    deskew_lane_fifo #(
      .DEPTH(DEPTH), .WORD_W(WORD_W), .PW(PW)
    ) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_word_i ({lane_mark_i[l], lane_data_i[l]}),
      .rd_dly_i  (dly_nxt[l]),
      .rd_word_o (rd_word[l])
    );
    assign lane_data_o[l] = out_q[l][CODE_W-1:0];
    assign lane_mark_o[l] = out_q[l][CODE_W];
  end

  // read with next-state delays so a completing column leaves on its own edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          out_q <= '0;
    else if (aligned_nxt) out_q <= rd_word;
    else                  out_q <= '0;
  end

  // R3
  col_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> (&lane_mark_o));

  // R2
  hold_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned_o |-> (lane_data_o == '0 && lane_mark_o == '0));
endmodule

// File: tb/lane_deskew_tb.sv
module lane_deskew_tb;
  import deskew_pkg::*;
  localparam int DEPTH = 8;
  localparam int SKEW  = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [LANES-1:0][CODE_W-1:0] din = '0;
  logic [3:0] sync = 4'hF;
  logic [3:0] mark = 4'h0;
  logic [LANES-1:0][CODE_W-1:0] dout;
  logic [3:0] mout;
  logic       aligned;

  always #10 clk = ~clk;

  lane_deskew #(.DEPTH(DEPTH), .SKEW_MAX(SKEW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lane_data_i(din), .lane_sync_i(sync),
    .lane_mark_i(mark), .lane_data_o(dout), .lane_mark_o(mout), .aligned_o(aligned)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model: absolute arrival times and input history
  int   hist[4][DEPTH];
  int   now = 0, t_first = 0;
  int   t_arr[4];
  int   m_dly[4];
  logic [3:0] got = 4'h0;
  bit   m_open = 0, m_al = 0;
  int   e_word[4];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic model_step();
    now++;
    for (int l = 0; l < 4; l++) begin
      for (int k = DEPTH - 1; k > 0; k--) hist[l][k] = hist[l][k-1];
      hist[l][0] = int'({mark[l], din[l]});
    end
    if (sync != 4'hF) begin
      m_open = 0; got = 4'h0; m_al = 0;
    end else begin
      if (!m_open && mark != 4'h0) begin m_open = 1; t_first = now; end
      if (m_open) begin
        for (int l = 0; l < 4; l++)
          if (mark[l] && !got[l]) begin got[l] = 1'b1; t_arr[l] = now; end
        if (got == 4'hF) begin
          for (int l = 0; l < 4; l++) m_dly[l] = now - t_arr[l];
          m_al = 1; m_open = 0; got = 4'h0;
        end else if (now - t_first >= SKEW) begin
          m_al = 0; m_open = 0; got = 4'h0;
        end
      end
    end
    for (int l = 0; l < 4; l++) e_word[l] = m_al ? hist[l][m_dly[l]] : 0;
  endtask

  task automatic step(input logic [3:0] m, input logic [3:0] s);
    for (int l = 0; l < 4; l++) din[l] = CODE_W'($urandom);
    mark = m;
    sync = s;
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int l = 0; l < 4; l++) check(cur_req, int'({mout[l], dout[l]}), e_word[l]);
    check(cur_req, int'(aligned), int'(m_al));
  endtask

  task automatic col(input int s0, input int s1, input int s2, input int s3,
                     input int gap, input int exp_al, input int exp_mk);
    int sk[4];
    int mx;
    sk = '{s0, s1, s2, s3};
    mx = 0;
    for (int l = 0; l < 4; l++) if (sk[l] > mx) mx = sk[l];
    for (int k = 0; k <= mx; k++) begin
      logic [3:0] m;
      for (int l = 0; l < 4; l++) m[l] = (sk[l] == k);
      step(m, 4'hF);
    end
    check(cur_req, int'(aligned), exp_al);
    check(cur_req, int'(mout), exp_mk);
    repeat (gap) step(4'h0, 4'hF);
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin
      t_arr[l] = 0; m_dly[l] = 0;
      for (int k = 0; k < DEPTH; k++) hist[l][k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(aligned), 0);
    check("R1", int'(dout), 0);
    check("R1", int'(mout), 0);
    rst_ni = 1'b1;

    // R2 unaligned output held at zero
    cur_req = "R2";
    repeat (10) step(4'h0, 4'hF);
    check("R2", int'(dout), 0);

    // R3 first column acquires
    cur_req = "R3";
    col(0, 3, 5, 1, 7, 1, 4'hF);

    // R9 same spacing repeats
    cur_req = "R9";
    col(0, 3, 5, 1, 23, 1, 4'hF);

    // R6 new spacing realigns at once
    cur_req = "R6";
    col(2, 0, 4, 4, 4, 1, 4'hF);

    // R4 long irregular gaps
    cur_req = "R4";
    col(0, 0, 0, 0, 40, 1, 4'hF);
    col(1, 5, 0, 2, 2, 1, 4'hF);

    // R8 repeated flag on lane 0 inside the window
    cur_req = "R8";
    step(4'b0001, 4'hF);
    step(4'b0000, 4'hF);
    step(4'b0001, 4'hF);
    step(4'b0000, 4'hF);
    step(4'b1110, 4'hF);
    check("R8", int'(aligned), 1);
    check("R8", int'(mout), 4'hF);
    repeat (6) step(4'h0, 4'hF);

    // R5 spread of 6 drops alignment
    cur_req = "R5";
    col(0, 6, 0, 0, 8, 0, 0);
    col(1, 1, 0, 0, 3, 1, 4'hF);
    // R5 lone flag: still aligned for 4 more cycles, dropped on the fifth
    step(4'b0100, 4'hF);
    repeat (4) step(4'h0, 4'hF);
    check("R5", int'(aligned), 1);
    step(4'h0, 4'hF);
    check("R5", int'(aligned), 0);

    // R7 sync loss on one lane
    cur_req = "R7";
    col(0, 0, 0, 0, 3, 1, 4'hF);
    step(4'h0, 4'b1011);
    check("R7", int'(aligned), 0);
    check("R7", int'(mout), 0);
    step(4'hF, 4'b1011);
    check("R7", int'(aligned), 0);
    check("R7", int'(mout), 0);
    step(4'h0, 4'hF);
    step(4'b0011, 4'hF);
    step(4'h0, 4'b0111);
    step(4'b1100, 4'hF);
    repeat (5) step(4'h0, 4'hF);
    check("R7", int'(aligned), 0);
    col(3, 0, 1, 2, 5, 1, 4'hF);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule